// File: doc/BRIEF.md
# Zero-Cross Switched Mute Attenuator

This block sits in a signed 16-bit audio sample path and scales each sample by one of three gain settings: unity, an attenuation of about 12 dB (a gain of one quarter), or full silence. A command byte chooses the setting. To avoid audible clicks, a newly requested setting is not applied at once. It is held as a pending request, and it takes effect on the first later sample that lies close to zero.

A sample counts as close to zero when its seven most significant bits are all equal, meaning all ones or all zeros. Each valid sample leaves the block one clock later, scaled by the gain in force for that sample. Between valid samples the output word holds its last value. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `mute_zc_atten`

## Requirements
- R1: While reset is asserted and just after it is released, `out_vld` is 0, `smp_out` is 0, the active gain is unity and no request is pending.
- R2: `out_vld` is 1 exactly one clock after a cycle in which `smp_vld` is 1, and 0 otherwise.
- R3: Under unity gain, a valid sample appears on `smp_out` unchanged one clock later.
- R4: Under attenuation, `smp_out` is the sample shifted right arithmetically by 2 (sign bit replicated), for example 0x8000 gives 0xE000 and 0xFFFF gives 0xFFFF.
- R5: Under full mute, `smp_out` is 0 for every valid sample.
- R6: A sample is at zero cross when bits 15 down to 9 are all 0 or all 1. For example, 0x01FF and 0xFE00 are at zero cross, while 0x0200 and 0xFDFF are not.
- R7: A pending gain becomes active only on a valid sample that is at zero cross, and that sample is itself scaled by the new gain. Samples that are not at zero cross keep the old gain.
- R8: Command 0x01 requests unity, 0x02 requests attenuation and 0x03 requests mute. A valid command replaces any older pending request that has not yet been applied.
- R9: Any other command code is ignored. It leaves both the active gain and the pending request unchanged.
- R10: When a command and a valid sample arrive in the same cycle, that sample is scaled by the gain in force before the command. The command becomes pending.
- R11: In a cycle without `smp_vld`, `smp_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | 16 | Signed input sample |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 8 | Gain command byte |
| out_vld | output | 1 | Output sample strobe |
| smp_out | output | 16 | Scaled signed output sample |

## Verification
Three events can fall in the same cycle: a new command arriving, a valid sample arriving, and an older pending request being applied at a zero cross. The stimulus table sets a command and a sample in one cycle and checks that the sample still uses the previous gain while the command becomes pending. Other table rows place a replacing command ahead of a zero-cross sample and expect the newer gain. An ignored code sent before a zero-cross sample must leave the earlier request intact, and the sample's output value shows whether it did.

// File: rtl/mute_pkg.sv
package mute_pkg;

  typedef enum logic [1:0] {
    GAIN_UNITY = 2'd0,
    GAIN_QUART = 2'd1,
    GAIN_SILENT = 2'd2
  } gain_t;

  localparam logic [7:0] CODE_UNITY  = 8'h01;
  localparam logic [7:0] CODE_QUART  = 8'h02;
  localparam logic [7:0] CODE_SILENT = 8'h03;

endpackage

// File: rtl/mute_cmd_decode.sv
module mute_cmd_decode
  import mute_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic [CMD_W-1:0] code,
  output logic             code_ok,
  output gain_t            code_gain
);

  always_comb begin
    code_ok   = 1'b1;
    code_gain = GAIN_UNITY;
    case (code)
      CMD_W'(CODE_UNITY):  code_gain = GAIN_UNITY;
      CMD_W'(CODE_QUART):  code_gain = GAIN_QUART;
      CMD_W'(CODE_SILENT): code_gain = GAIN_SILENT;
      default:             code_ok   = 1'b0;
    endcase
  end

endmodule

// File: rtl/mute_zc_detect.sv
module mute_zc_detect #(
  parameter int DATA_W  = 16,
  parameter int ZC_BITS = 7
) (
  input  logic [DATA_W-1:0] smp,
  output logic              zc
);

  localparam int TOP = DATA_W - 1;

  logic [ZC_BITS-1:0] head;

  always_comb begin
    head = smp[TOP -: ZC_BITS];
    zc   = (&head) | ~(|head);
  end

endmodule

// File: rtl/mute_gain_apply.sv
module mute_gain_apply
  import mute_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ATT_SHIFT = 2
) (
  input  logic [DATA_W-1:0] smp,
  input  gain_t             gain,
  output logic [DATA_W-1:0] scaled
);

  logic signed [DATA_W-1:0] smp_s;

  always_comb begin
    smp_s = $signed(smp);
    case (gain)
      GAIN_QUART:  scaled = DATA_W'(smp_s >>> ATT_SHIFT);
      GAIN_SILENT: scaled = '0;
      default:     scaled = smp;
    endcase
  end

endmodule

// File: rtl/mute_zc_atten.sv
module mute_zc_atten
  import mute_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CMD_W     = 8,
  parameter int ZC_BITS   = 7,
  parameter int ATT_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic              out_vld,
  output logic [DATA_W-1:0] smp_out
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // sub-blocks
  logic              code_ok;
  gain_t             code_gain;
  logic              zc_hit;
  gain_t             eff_gain;
  logic [DATA_W-1:0] scaled;

  mute_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .code      (cmd_code),
    .code_ok   (code_ok),
    .code_gain (code_gain)
  );

  mute_zc_detect #(.DATA_W(DATA_W), .ZC_BITS(ZC_BITS)) u_zc (
    .smp (smp_in),
    .zc  (zc_hit)
  );

  mute_gain_apply #(.DATA_W(DATA_W), .ATT_SHIFT(ATT_SHIFT)) u_apply (
    .smp    (smp_in),
    .gain   (eff_gain),
    .scaled (scaled)
  );

  // state
  gain_t             cur_gain, cur_gain_n;
  gain_t             pend_gain, pend_gain_n;
  logic              pend_vld, pend_vld_n;
  logic              commit;
  logic [DATA_W-1:0] out_q, out_n;
  logic              vld_q, vld_n;

  always_comb begin
    commit      = smp_vld & pend_vld & zc_hit;
    eff_gain    = commit ? pend_gain : cur_gain;
    cur_gain_n  = smp_vld ? eff_gain : cur_gain;
    pend_vld_n  = pend_vld;
    pend_gain_n = pend_gain;
    if (cmd_vld && code_ok) begin
      pend_vld_n  = 1'b1;
      pend_gain_n = code_gain;
    end else if (commit) begin
      pend_vld_n  = 1'b0;
    end
    out_n = smp_vld ? scaled : out_q;
    vld_n = smp_vld;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cur_gain  <= GAIN_UNITY;
      pend_gain <= GAIN_UNITY;
      pend_vld  <= 1'b0;
      out_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      cur_gain  <= cur_gain_n;
      pend_gain <= pend_gain_n;
      pend_vld  <= pend_vld_n;
      out_q     <= out_n;
      vld_q     <= vld_n;
    end
  end

  assign out_vld = vld_q;
  assign smp_out = out_q;

  // R2: strobe follows one cycle later
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    smp_vld |=> out_vld);
  a_r2_vld_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !smp_vld |=> !out_vld);
  // R5: muted sample leaves as zero
  a_r5_mute_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_vld && eff_gain == GAIN_SILENT) |=> (smp_out == '0));
  // R7: active gain moves only on a zero-cross sample with a request pending
  a_r7_gain_only_at_zc: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(smp_vld && zc_hit && pend_vld) |=> $stable(cur_gain));
  // R9: an unknown code leaves the request untouched
  a_r9_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_vld && !code_ok && !commit) |=> ($stable(pend_vld) && $stable(pend_gain)));
  // R11: output word holds without a sample
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !smp_vld |=> $stable(smp_out));

endmodule

// File: tb/mute_zc_atten_test.sv
module mute_zc_atten_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [15:0] smp_in;
  logic        cmd_vld;
  logic [7:0]  cmd_code;
  logic        out_vld;
  logic [15:0] smp_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mute_zc_atten uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .out_vld(out_vld), .smp_out(smp_out)
  );

  // entry: {cmd_vld, cmd_code, smp_vld, smp_in, exp_vld, exp_out}
  localparam int NV = 21;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 16'h1234, 1'b1, 16'h1234}, // R3 unity pass
    {1'b1, 8'h02, 1'b1, 16'h4000, 1'b1, 16'h4000}, // R10 same-cycle uses old gain
    {1'b0, 8'h00, 1'b1, 16'h4000, 1'b1, 16'h4000}, // R7 not zc, old gain
    {1'b0, 8'h00, 1'b1, 16'h0100, 1'b1, 16'h0040}, // R7 zc applies quarter
    {1'b0, 8'h00, 1'b1, 16'h8000, 1'b1, 16'hE000}, // R4 arithmetic shift
    {1'b0, 8'h00, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF}, // R4 minus one stays
    {1'b1, 8'h03, 1'b0, 16'h0000, 1'b0, 16'hFFFF}, // R11 hold
    {1'b1, 8'h01, 1'b0, 16'h0000, 1'b0, 16'hFFFF}, // R8 replace pending
    {1'b0, 8'h00, 1'b1, 16'h7000, 1'b1, 16'h1C00}, // R7 not zc keeps quarter
    {1'b0, 8'h00, 1'b1, 16'h01FF, 1'b1, 16'h01FF}, // R8 newer unity applied
    {1'b1, 8'h03, 1'b0, 16'h0000, 1'b0, 16'h01FF}, // R11 hold
    {1'b0, 8'h00, 1'b1, 16'hFE00, 1'b1, 16'h0000}, // R6 all-ones head zc
    {1'b0, 8'h00, 1'b1, 16'h7FFF, 1'b1, 16'h0000}, // R5 mute
    {1'b1, 8'h01, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R8 request unity
    {1'b1, 8'hFF, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R9 bad code
    {1'b0, 8'h00, 1'b1, 16'h0200, 1'b1, 16'h0000}, // R6 0x0200 not zc
    {1'b0, 8'h00, 1'b1, 16'hFDFF, 1'b1, 16'h0000}, // R6 0xFDFF not zc
    {1'b0, 8'h00, 1'b1, 16'h0150, 1'b1, 16'h0150}, // R9 request survived
    {1'b1, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0150}, // R9 bad code
    {1'b0, 8'h00, 1'b1, 16'hFE10, 1'b1, 16'hFE10}, // R9 gain unchanged
    {1'b0, 8'h00, 1'b0, 16'h0000, 1'b0, 16'hFE10}  // R2 idle
  };

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [7:0] cc, input logic sv, input logic [15:0] sd);
    @(negedge clk);
    cmd_vld = cv; cmd_code = cc; smp_vld = sv; smp_in = sd;
    @(posedge clk);
    #1;
    cmd_vld = 1'b0; smp_vld = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_in = '0; cmd_vld = 1'b0; cmd_code = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {out_vld, smp_out}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {out_vld, smp_out}, 17'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][42], VEC[i][41:34], VEC[i][33], VEC[i][32:17]);
      check($sformatf("vector %0d (R2-R11)", i), {out_vld, smp_out}, VEC[i][16:0]);
    end

    // R4 positive small value
    step(1'b1, 8'h02, 1'b0, 16'h0);
    step(1'b0, 8'h00, 1'b1, 16'h0007);
    check("R4 zc 0x0007 quarter", {out_vld, smp_out}, {1'b1, 16'h0001});
    // R1 reset clears active gain back to unity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {out_vld, smp_out}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 8'h00, 1'b1, 16'h0800);
    check("R1 unity after reset", {out_vld, smp_out}, {1'b1, 16'h0800});
    step(1'b0, 8'h00, 1'b0, 16'h0);
    check("R2 no strobe", {out_vld, smp_out}, {1'b0, 16'h0800});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule